// File: doc/BRIEF.md
# Registered Integer ALU

This block is the arithmetic logic unit for the execute stage of a small load/store processor. Every cycle it takes two operands and a three-bit function code. It returns a result word and three flags: zero, signed overflow and carry-out. It computes bitwise AND and OR, addition, subtraction and a signed set-on-less-than. One adder does all of the arithmetic. When the high bit of the function code is set, the adder receives the complement of B and a carry-in of one. The less-than answer comes from the sign of that difference, corrected by the overflow bit.

The result and the flags are computed combinationally and captured in one register stage. The outputs for the operands presented before a rising clock edge are therefore visible after that edge. Branch logic can test equality of two registers by subtracting them and looking at the zero flag.

Top module: `alu_core`

## Requirements
- R1: Function code 3'b000 gives the bitwise AND of A and B. Overflow and carry-out are 0.
- R2: Function code 3'b001 gives the bitwise OR of A and B. Overflow and carry-out are 0.
- R3: Function code 3'b010 gives A+B modulo 2^WIDTH. Carry-out is the unsigned carry out of the top bit.
- R4: Function code 3'b110 gives A-B, formed as A + ~B + 1. Carry-out is 1 exactly when A >= B as unsigned numbers.
- R5: For codes 3'b010 and 3'b110, overflow is 1 exactly when the signed two's-complement result does not fit in WIDTH bits.
- R6: Function code 3'b111 gives 1 when A < B as signed numbers and 0 otherwise, zero-extended to WIDTH bits. The answer is correct even when A-B overflows. Overflow and carry-out are 0.
- R7: For codes 000, 001, 010, 110 and 111, the zero flag is 1 exactly when every result bit is 0.
- R8: Overflow and carry-out are 0 for every code other than 3'b010 and 3'b110.
- R9: Codes 3'b011, 3'b100 and 3'b101 are unused. Each gives a result of 0 with zero, overflow and carry-out all 0.
- R10: The outputs show the operands and code sampled at the most recent rising clock edge, one cycle of latency. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| func_sel | input | 3 | Function code |
| res_q | output | WIDTH | Registered result |
| zero_q | output | 1 | Result is all zeros (defined codes only) |
| ovf_q | output | 1 | Signed overflow of add or subtract |
| cout_q | output | 1 | Carry out of the top adder bit |

## Verification
The bench first targets signed overflow at the edges of the range. Examples are the most positive value plus one, and the most negative value minus one. A design that took overflow from the carry-out alone would flag unsigned wraps and miss signed ones. It then compares operands whose difference overflows. A less-than that read only the sign of the difference would give the inverted answer for these, such as the most negative value against a positive one. Equal operands under subtraction must set the zero flag and carry-out together. A design that kept a borrow instead of a carry would clear carry-out there. The unused codes are driven with operands that would give a zero result, to catch a zero flag that follows the result word instead of being cleared.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam logic [2:0] FN_AND = 3'b000;
    localparam logic [2:0] FN_OR  = 3'b001;
    localparam logic [2:0] FN_ADD = 3'b010;
    localparam logic [2:0] FN_SUB = 3'b110;
    localparam logic [2:0] FN_SLT = 3'b111;

    // bit of the function code that turns the adder into a subtractor
    localparam int unsigned NEG_B_BIT = 2;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic cout;
    } alu_flags_t;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_msb_o,
    output logic             cout_o
);

    localparam int unsigned LOW_W = WIDTH - 1;

    logic [LOW_W:0] low_sum;
    logic [1:0]     top_sum;

    // low bits first, so the carry into the top bit is visible on its own
    assign low_sum = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]}
                   + {{LOW_W{1'b0}}, cin_i};
    assign top_sum = {1'b0, a_i[LOW_W]} + {1'b0, b_i[LOW_W]}
                   + {1'b0, low_sum[LOW_W]};

    assign sum_o   = {top_sum[0], low_sum[LOW_W-1:0]};
    assign c_msb_o = low_sum[LOW_W];
    assign cout_o  = top_sum[1];

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit (
    input  logic c_msb_i,
    input  logic cout_i,
    input  logic sum_sign_i,
    output logic ovf_o,
    output logic less_o
);

    assign ovf_o  = c_msb_i ^ cout_i;
    // the sign of the difference is wrong exactly when the difference overflowed
    assign less_o = sum_sign_i ^ ovf_o;

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       func_sel,
    output logic [WIDTH-1:0] res_q,
    output logic             zero_q,
    output logic             ovf_q,
    output logic             cout_q
);

    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum_w;
    logic             neg_b;
    logic             c_msb_w;
    logic             cout_w;
    logic             ovf_w;
    logic             less_w;

    logic [WIDTH-1:0] res_d;
    logic [WIDTH-1:0] res_r;
    alu_flags_t       flags_d;
    alu_flags_t       flags_q;

    assign neg_b = func_sel[NEG_B_BIT];
    assign b_eff = neg_b ? ~opnd_b : opnd_b;

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .and_o (and_w),
        .or_o  (or_w)
    );

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i     (opnd_a),
        .b_i     (b_eff),
        .cin_i   (neg_b),
        .sum_o   (sum_w),
        .c_msb_o (c_msb_w),
        .cout_o  (cout_w)
    );

    alu_flag_unit u_flags (
        .c_msb_i    (c_msb_w),
        .cout_i     (cout_w),
        .sum_sign_i (sum_w[WIDTH-1]),
        .ovf_o      (ovf_w),
        .less_o     (less_w)
    );

    always_comb begin
        res_d         = '0;
        flags_d       = '0;
        unique case (func_sel)
            FN_AND: res_d = and_w;
            FN_OR:  res_d = or_w;
            FN_ADD, FN_SUB: begin
                res_d        = sum_w;
                flags_d.ovf  = ovf_w;
                flags_d.cout = cout_w;
            end
            FN_SLT: res_d = {{(WIDTH-1){1'b0}}, less_w};
            default: res_d = '0;
        endcase
        unique case (func_sel)
            FN_AND, FN_OR, FN_ADD, FN_SUB, FN_SLT: flags_d.zero = (res_d == '0);
            default:                               flags_d.zero = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_r   <= '0;
            flags_q <= '0;
        end else begin
            res_r   <= res_d;
            flags_q <= flags_d;
        end
    end

    assign res_q  = res_r;
    assign zero_q = flags_q.zero;
    assign ovf_q  = flags_q.ovf;
    assign cout_q = flags_q.cout;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       func_sel,
    input logic [WIDTH-1:0] res_q,
    input logic             zero_q,
    input logic             ovf_q,
    input logic             cout_q
);

    p_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b000) |=> (res_q == ($past(opnd_a) & $past(opnd_b))));

    p_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b001) |=> (res_q == ($past(opnd_a) | $past(opnd_b))));

    p_slt_binary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b111) |=> (res_q[WIDTH-1:1] == '0));

    p_zero_means_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |-> (res_q == '0));

    p_no_arith_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel != 3'b010 && func_sel != 3'b110) |=> (!ovf_q && !cout_q));

    p_unused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b011 || func_sel == 3'b100 || func_sel == 3'b101)
        |=> (res_q == '0 && !zero_q && !ovf_q && !cout_q));

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .func_sel (func_sel),
    .res_q    (res_q),
    .zero_q   (zero_q),
    .ovf_q    (ovf_q),
    .cout_q   (cout_q)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] opnd_a = '0;
    logic [WIDTH-1:0] opnd_b = '0;
    logic [2:0]       func_sel = 3'b000;
    logic [WIDTH-1:0] res_q;
    logic             zero_q;
    logic             ovf_q;
    logic             cout_q;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core #(.WIDTH(WIDTH)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .func_sel (func_sel),
        .res_q    (res_q),
        .zero_q   (zero_q),
        .ovf_q    (ovf_q),
        .cout_q   (cout_q)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural model: computes expected outputs from integers
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [2:0] fn);
        longint ua, ub, full;
        longint sa, sb;
        logic [31:0] r;
        logic z, v, c;
        string tr;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        r = '0; z = 1'b0; v = 1'b0; c = 1'b0;
        case (fn)
            3'b000: begin r = a & b; tr = "R1"; end
            3'b001: begin r = a | b; tr = "R2"; end
            3'b010: begin
                full = ua + ub; r = full[31:0]; c = full[32];
                v = ((sa + sb) > 64'sd2147483647) || ((sa + sb) < -64'sd2147483648);
                tr = "R3/R5";
            end
            3'b110: begin
                r = a - b; c = (ua >= ub);
                v = ((sa - sb) > 64'sd2147483647) || ((sa - sb) < -64'sd2147483648);
                tr = "R4/R5";
            end
            3'b111: begin r = (sa < sb) ? 32'd1 : 32'd0; tr = "R6"; end
            default: begin r = '0; tr = "R9"; end
        endcase
        if (fn inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111}) z = (r == '0);
        @(negedge clk);
        opnd_a = a; opnd_b = b; func_sel = fn;
        @(negedge clk);
        check({tr, " result (R10 latency)"}, longint'(res_q), longint'(r));
        check({tr, " zero R7"}, longint'(zero_q), longint'(z));
        check({tr, " overflow R8"}, longint'(ovf_q), longint'(v));
        check({tr, " carry R8"}, longint'(cout_q), longint'(c));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF; func_sel = 3'b010;
        repeat (3) @(negedge clk);
        // R10: outputs cleared while held in reset
        check("R10 reset result", longint'(res_q), 0);
        check("R10 reset zero", longint'(zero_q), 0);
        check("R10 reset overflow", longint'(ovf_q), 0);
        check("R10 reset carry", longint'(cout_q), 0);
        rst_n = 1'b1;

        run_op(32'hF0F0_1234, 32'h0FF0_FF00, 3'b000);   // R1
        run_op(32'h0F0F_0000, 32'hF0F0_0000, 3'b000);   // R1 zero result
        run_op(32'h0F0F_0000, 32'h00F0_0001, 3'b001);   // R2
        run_op(32'h0, 32'h0, 3'b001);                   // R2 zero
        run_op(32'h7FFF_FFFF, 32'h1, 3'b010);           // R5 positive overflow
        run_op(32'hFFFF_FFFF, 32'h1, 3'b010);           // R3 carry, zero
        run_op(32'h8000_0000, 32'h8000_0000, 3'b010);   // R5 negative overflow
        run_op(32'h1234, 32'h1234, 3'b110);             // R4 equal: zero and carry
        run_op(32'h8000_0000, 32'h1, 3'b110);           // R5 sub overflow
        run_op(32'h1, 32'h2, 3'b110);                   // R4 borrow
        run_op(32'h8000_0000, 32'h7FFF_FFFF, 3'b111);   // R6 overflowed diff, less
        run_op(32'h7FFF_FFFF, 32'h8000_0000, 32'h7);    // R6 not less
        run_op(32'hFFFF_FFFF, 32'h0, 3'b111);           // R6 -1 < 0
        run_op(32'h5, 32'h5, 3'b111);                   // R6 equal -> 0, zero
        run_op(32'h0, 32'h0, 3'b011);                   // R9
        run_op(32'hFFFF_FFFF, 32'h1, 3'b100);           // R9
        run_op(32'h8000_0000, 32'h8000_0000, 3'b101);   // R9

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            logic [2:0]  rf;
            ra = $urandom; rb = $urandom; rf = 3'($urandom);
            if (i % 5 == 0) rb = ra;
            if (i % 7 == 0) ra = {ra[31], 31'h0};
            run_op(ra, rb, rf);
        end

        // R10: reset again mid-stream
        @(negedge clk);
        opnd_a = 32'h1; opnd_b = 32'h1; func_sel = 3'b001; rst_n = 1'b0;
        @(negedge clk);
        check("R10 second reset result", longint'(res_q), 0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule